// File: doc/BRIEF.md
# Block-Cipher Accelerator Control and Status Register

This block is the single 16-bit control and status word of a block-cipher accelerator. Software reaches it over a plain peripheral bus (address, write enable, read enable, write data, combinational read data). The word holds a two-bit operation selector, an interrupt enable for the completion event, a completion flag, an error flag and a self-clearing software reset command. The cipher engine itself lives elsewhere. This block sees the engine through a busy level and a done pulse. It also sees three strobes that mark bus accesses to the engine's key, input-data and output-data ports.

The two flags change mostly as side effects. A done pulse raises the completion flag. Loading a new key or new input data, or fetching the result, lowers it. Loading a key or input data while the engine is still working raises the error flag, which stays up until software writes it to zero.

A write that carries the reset command produces a one-cycle reset pulse to the engine and clears both flags. It leaves the operation selector and the interrupt enable untouched. The block drives the selected mode, a start hint, the engine reset pulse and a level interrupt.

Top module: `cacc_ctl`

## Requirements
- R1: Bits 15:13, 10:9 and 6:2 of the control word always read 0, whatever was written to them. Bit 7 (reset command) also always reads 0.
- R2: Bits 1:0 hold the operation selector and drive `op_mode`. The encodings are: 00 encrypt, 01 decrypt with the encryption key, 10 derive the first decryption round key, 11 decrypt with an already derived round key. All four values read back as written.
- R3: Bit 12 is the interrupt enable. `irq` is high exactly when the enable and the completion flag (bit 8) are both 1.
- R4: An `eng_done` pulse sets the completion flag (bit 8) at the next clock edge.
- R5: A strobe on `dout_rd`, `key_wr` or `din_wr` clears the completion flag, and this beats a software write of the flag in the same cycle. A done pulse in the same cycle beats both. Without these events, a control write loads bit 8 from the write data.
- R6: A strobe on `key_wr` or `din_wr` while `eng_busy` is 1 sets the error flag (bit 11). The same strobes while `eng_busy` is 0 leave it unchanged.
- R7: Without a new error event, the error flag changes only by a control write, which loads bit 11 from the write data. Writing 0 is the only way software clears it.
- R8: A control write with bit 7 set clears both flags and drives `eng_rst` high for exactly the following cycle. It does not change bits 12 or 1:0.
- R9: During the `eng_rst` cycle the flags stay 0. Done pulses and key or data strobes in that cycle are ignored, because the engine is regarded as idle.
- R10: `start_hint` is high in any cycle with a `din_wr` strobe while `eng_busy` is 0 and `eng_rst` is 0.
- R11: `rdata` is 0 unless `rd_en` is 1 and `addr` equals the control word address.
- R12: A synchronous hardware reset clears every field, including the interrupt enable and the operation selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| addr | input | ADDR_W | Bus word address |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 16 | Bus write data |
| rdata | output | 16 | Bus read data (combinational) |
| eng_busy | input | 1 | Engine is working on an operation |
| eng_done | input | 1 | One-cycle pulse at operation completion |
| key_wr | input | 1 | Bus write to the key port this cycle |
| din_wr | input | 1 | Bus write to the input-data port this cycle |
| dout_rd | input | 1 | Bus read of the output-data port this cycle |
| op_mode | output | 2 | Selected operation |
| start_hint | output | 1 | Input data loaded while engine idle |
| eng_rst | output | 1 | One-cycle engine reset pulse |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach is the single cycle in which `eng_rst` is high. Flags must stay clear there even though the engine still reports busy and may emit a done pulse or see a key write. The bench reaches it by issuing the reset-command write and then, in the very next low clock phase, driving `eng_busy`, `eng_done` and `key_wr` together before the pulse ends. The bench then reads the word back and expects clean flags, with the spared selector and enable intact. Same-cycle collisions of done with clearing strobes are driven the same way.

// File: rtl/cacc_pkg.sv
package cacc_pkg;

    localparam int unsigned CTL_W     = 16;
    localparam int unsigned OP_W      = 2;
    localparam int unsigned OP_LSB    = 0;
    localparam int unsigned SWRST_BIT = 7;
    localparam int unsigned RDY_BIT   = 8;
    localparam int unsigned ERR_BIT   = 11;
    localparam int unsigned IE_BIT    = 12;

    // Bits that hold state; everything else reads as zero.
    localparam logic [CTL_W-1:0] LIVE_MASK =
        (CTL_W'(1) << IE_BIT) | (CTL_W'(1) << ERR_BIT) |
        (CTL_W'(1) << RDY_BIT) | (CTL_W'((1 << OP_W) - 1) << OP_LSB);

    typedef enum logic [OP_W-1:0] {
        OP_ENCRYPT    = 2'b00,
        OP_DECRYPT    = 2'b01,
        OP_DERIVE_KEY = 2'b10,
        OP_DECRYPT_RK = 2'b11
    } cacc_op_e;

    typedef struct packed {
        cacc_op_e op;
        logic     ie;
        logic     rdy;
        logic     err;
    } cacc_fields_t;

    typedef struct packed {
        logic ctl_wr;
        logic ctl_rd;
        logic swrst_req;
    } cacc_bus_ev_t;

    typedef struct packed {
        logic rdy_set;
        logic rdy_clr;
        logic err_set;
        logic flush;
    } cacc_flag_ev_t;

    function automatic logic [CTL_W-1:0] cacc_pack(cacc_fields_t f);
        logic [CTL_W-1:0] v;
        v = '0;
        v[OP_LSB +: OP_W] = f.op;
        v[IE_BIT]         = f.ie;
        v[RDY_BIT]        = f.rdy;
        v[ERR_BIT]        = f.err;
        return v & LIVE_MASK;
    endfunction

endpackage

// File: rtl/cacc_bus_dec.sv
module cacc_bus_dec
    import cacc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CTL_ADDR = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              swrst_bit,
    output cacc_bus_ev_t      ev
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTL_ADDR);

    logic hit;

    always_comb begin
        hit          = (addr == HIT_ADDR);
        ev.ctl_wr    = wr_en & hit;
        ev.ctl_rd    = rd_en & hit;
        ev.swrst_req = wr_en & hit & swrst_bit;
    end
endmodule

// File: rtl/cacc_swrst_gen.sv
module cacc_swrst_gen (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= req;
    end
endmodule

// File: rtl/cacc_mode_reg.sv
module cacc_mode_reg
    import cacc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ctl_wr,
    input  logic     swrst_req,
    input  cacc_op_e wr_op,
    input  logic     wr_ie,
    output cacc_op_e op,
    output logic     ie
);
    // A write that carries the reset command does not touch these fields.
    logic load;

    always_comb load = ctl_wr & ~swrst_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            op <= OP_ENCRYPT;
            ie <= 1'b0;
        end else if (load) begin
            op <= wr_op;
            ie <= wr_ie;
        end
    end
endmodule

// File: rtl/cacc_flag_unit.sv
module cacc_flag_unit
    import cacc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_wr,
    input  logic          wr_rdy,
    input  logic          wr_err,
    input  cacc_flag_ev_t ev,
    output logic          rdy,
    output logic          err
);
    logic rdy_n;
    logic err_n;

    // Priority, lowest first: software load, auto-clear, done, reset flush.
    always_comb begin
        rdy_n = rdy;
        if (ctl_wr)     rdy_n = wr_rdy;
        if (ev.rdy_clr) rdy_n = 1'b0;
        if (ev.rdy_set) rdy_n = 1'b1;
        if (ev.flush)   rdy_n = 1'b0;

        err_n = err;
        if (ctl_wr)     err_n = wr_err;
        if (ev.err_set) err_n = 1'b1;
        if (ev.flush)   err_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy <= 1'b0;
            err <= 1'b0;
        end else begin
            rdy <= rdy_n;
            err <= err_n;
        end
    end
endmodule

// File: rtl/cacc_ctl.sv
module cacc_ctl
    import cacc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CTL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              key_wr,
    input  logic              din_wr,
    input  logic              dout_rd,
    output logic [1:0]        op_mode,
    output logic              start_hint,
    output logic              eng_rst,
    output logic              irq
);
    cacc_bus_ev_t  bus_ev;
    cacc_flag_ev_t flag_ev;
    cacc_fields_t  fields;
    cacc_op_e      op_q;
    logic          ie_q;
    logic          rdy_q;
    logic          err_q;
    logic          busy_eff;

    cacc_bus_dec #(
        .ADDR_W   (ADDR_W),
        .CTL_ADDR (CTL_ADDR)
    ) u_dec (
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .swrst_bit (wdata[SWRST_BIT]),
        .ev        (bus_ev)
    );

    cacc_swrst_gen u_rstgen (
        .clk   (clk),
        .rst   (rst),
        .req   (bus_ev.swrst_req),
        .pulse (eng_rst)
    );

    cacc_mode_reg u_mode (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (bus_ev.ctl_wr),
        .swrst_req (bus_ev.swrst_req),
        .wr_op     (cacc_op_e'(wdata[OP_LSB +: OP_W])),
        .wr_ie     (wdata[IE_BIT]),
        .op        (op_q),
        .ie        (ie_q)
    );

    // Engine counts as idle while its reset pulse is out.
    always_comb begin
        busy_eff        = eng_busy & ~eng_rst;
        flag_ev.rdy_set = eng_done;
        flag_ev.rdy_clr = dout_rd | key_wr | din_wr;
        flag_ev.err_set = (key_wr | din_wr) & busy_eff;
        flag_ev.flush   = bus_ev.swrst_req | eng_rst;
    end

    cacc_flag_unit u_flags (
        .clk    (clk),
        .rst    (rst),
        .ctl_wr (bus_ev.ctl_wr),
        .wr_rdy (wdata[RDY_BIT]),
        .wr_err (wdata[ERR_BIT]),
        .ev     (flag_ev),
        .rdy    (rdy_q),
        .err    (err_q)
    );

    always_comb begin
        fields.op  = op_q;
        fields.ie  = ie_q;
        fields.rdy = rdy_q;
        fields.err = err_q;
        rdata      = bus_ev.ctl_rd ? cacc_pack(fields) : '0;
        op_mode    = op_q;
        irq        = rdy_q & ie_q;
        start_hint = din_wr & ~eng_busy & ~eng_rst;
    end
endmodule

// File: rtl/cacc_ctl_chk.sv
module cacc_ctl_chk #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CTL_ADDR = 0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [15:0]       wdata,
    input logic [15:0]       rdata,
    input logic              eng_busy,
    input logic              eng_done,
    input logic              key_wr,
    input logic              din_wr,
    input logic              dout_rd,
    input logic [1:0]        op_mode,
    input logic              eng_rst,
    input logic              irq,
    input logic              rdy,
    input logic              err,
    input logic              ie
);
    localparam logic [15:0] DEAD_BITS = 16'hE6FC;

    logic cw;
    logic sw;

    always_comb begin
        cw = wr_en && (addr == ADDR_W'(CTL_ADDR));
        sw = cw && wdata[7];
    end

    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(CTL_ADDR)) |-> ((rdata & DEAD_BITS) == 16'h0));

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cw |=> $stable(op_mode));

    p_irq_gate_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie);

    p_done_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !eng_rst && !sw) |=> rdy);

    p_auto_clear_r5: assert property (@(posedge clk) disable iff (rst)
        ((dout_rd || key_wr || din_wr) && !eng_done) |=> !rdy);

    p_err_set_r6: assert property (@(posedge clk) disable iff (rst)
        ((key_wr || din_wr) && eng_busy && !eng_rst && !sw) |=> err);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (err && !cw && !eng_rst) |=> err);

    p_rst_follows_r8: assert property (@(posedge clk) disable iff (rst)
        sw |=> eng_rst);

    p_rst_single_r8: assert property (@(posedge clk) disable iff (rst)
        (eng_rst && !sw) |=> !eng_rst);

    p_flags_flushed_r9: assert property (@(posedge clk) disable iff (rst)
        eng_rst |=> (!rdy && !err));

    p_read_gate_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == 16'h0));
endmodule

bind cacc_ctl cacc_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .CTL_ADDR (CTL_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .eng_busy (eng_busy),
    .eng_done (eng_done),
    .key_wr   (key_wr),
    .din_wr   (din_wr),
    .dout_rd  (dout_rd),
    .op_mode  (op_mode),
    .eng_rst  (eng_rst),
    .irq      (irq),
    .rdy      (rdy_q),
    .err      (err_q),
    .ie       (ie_q)
);

// File: tb/sim_cacc_ctl.sv
module sim_cacc_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int CTLA       = 0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          eng_busy = 1'b0;
    logic          eng_done = 1'b0;
    logic          key_wr = 1'b0;
    logic          din_wr = 1'b0;
    logic          dout_rd = 1'b0;
    logic [1:0]    op_mode;
    logic          start_hint;
    logic          eng_rst;
    logic          irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cacc_ctl #(.ADDR_W(AW), .CTL_ADDR(CTLA)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .eng_busy(eng_busy), .eng_done(eng_done),
        .key_wr(key_wr), .din_wr(din_wr), .dout_rd(dout_rd), .op_mode(op_mode),
        .start_hint(start_hint), .eng_rst(eng_rst), .irq(irq)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ctl_write(logic [15:0] d);
        @(negedge clk);
        addr = AW'(CTLA); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic ctl_read(logic [AW-1:0] a, output logic [15:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic strobe(bit dn, bit kw, bit dw, bit dr);
        @(negedge clk);
        eng_done = dn; key_wr = kw; din_wr = dw; dout_rd = dr;
        @(negedge clk);
        eng_done = 0; key_wr = 0; din_wr = 0; dout_rd = 0;
    endtask

    task automatic hw_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        hw_reset();
        ctl_read(AW'(CTLA), d);
        check("R12 word after reset", d, 16'h0000);
        check("R12 outputs after reset", {13'b0, irq, eng_rst, op_mode}, 16'h0);
    endtask

    task automatic t_modes();
        logic [15:0] d;
        for (int m = 0; m < 4; m++) begin
            ctl_write(16'(m));
            ctl_read(AW'(CTLA), d);
            check("R2 selector readback", d, 16'(m));
            check("R2 op_mode output", {14'b0, op_mode}, 16'(m));
        end
    endtask

    task automatic t_reserved();
        logic [15:0] d;
        ctl_write(16'hFF7F);
        ctl_read(AW'(CTLA), d);
        check("R1 dead bits read zero", d, 16'h1903);
        check("R3 irq with enable and flag", {15'b0, irq}, 16'h1);
        ctl_read(AW'(CTLA + 1), d);
        check("R11 other address reads zero", d, 16'h0);
        #1 check("R11 idle bus reads zero", rdata, 16'h0);
        ctl_write(16'h0000);
    endtask

    task automatic t_ready_irq();
        logic [15:0] d;
        strobe(1, 0, 0, 0);
        ctl_read(AW'(CTLA), d);
        check("R4 done sets flag", d, 16'h0100);
        check("R3 irq off when disabled", {15'b0, irq}, 16'h0);
        ctl_write(16'h1100);
        check("R3 irq on when enabled", {15'b0, irq}, 16'h1);
    endtask

    task automatic t_auto_clear();
        logic [15:0] d;
        strobe(0, 0, 0, 1);
        ctl_read(AW'(CTLA), d);
        check("R5 result read clears flag", d, 16'h1000);
        check("R3 irq follows flag", {15'b0, irq}, 16'h0);
        strobe(1, 0, 0, 0);
        strobe(0, 1, 0, 0);
        ctl_read(AW'(CTLA), d);
        check("R5 key write clears flag", d, 16'h1000);
        strobe(1, 0, 0, 0);
        strobe(0, 0, 1, 0);
        ctl_read(AW'(CTLA), d);
        check("R5 data write clears flag", d, 16'h1000);
        strobe(1, 0, 0, 1);
        ctl_read(AW'(CTLA), d);
        check("R5 done beats clear", d, 16'h1100);
        ctl_write(16'h0000);
        ctl_read(AW'(CTLA), d);
        check("R5 software clears flag", d, 16'h0000);
        ctl_write(16'h0100);
        ctl_read(AW'(CTLA), d);
        check("R5 software sets flag", d, 16'h0100);
        ctl_write(16'h0000);
    endtask

    task automatic t_error();
        logic [15:0] d;
        strobe(0, 1, 0, 0);
        ctl_read(AW'(CTLA), d);
        check("R6 idle key write no error", d, 16'h0000);
        eng_busy = 1'b1;
        strobe(0, 1, 0, 0);
        eng_busy = 1'b0;
        ctl_read(AW'(CTLA), d);
        check("R6 busy key write sets error", d, 16'h0800);
        ctl_write(16'h0801);
        ctl_read(AW'(CTLA), d);
        check("R7 writing 1 keeps error", d, 16'h0801);
        ctl_write(16'h0001);
        ctl_read(AW'(CTLA), d);
        check("R7 writing 0 clears error", d, 16'h0001);
        eng_busy = 1'b1;
        strobe(0, 0, 1, 0);
        eng_busy = 1'b0;
        ctl_read(AW'(CTLA), d);
        check("R6 busy data write sets error", d, 16'h0801);
        ctl_write(16'h0000);
    endtask

    task automatic t_swrst();
        logic [15:0] d;
        ctl_write(16'h1902);
        ctl_write(16'h0080);
        check("R8 engine reset pulse high", {15'b0, eng_rst}, 16'h1);
        eng_busy = 1'b1; eng_done = 1'b1; key_wr = 1'b1;
        ctl_read(AW'(CTLA), d);
        check("R8 flags cleared, fields spared", d, 16'h1002);
        check("R8 irq low", {15'b0, irq}, 16'h0);
        @(negedge clk);
        eng_busy = 1'b0; eng_done = 1'b0; key_wr = 1'b0;
        check("R8 pulse lasts one cycle", {15'b0, eng_rst}, 16'h0);
        ctl_read(AW'(CTLA), d);
        check("R9 events ignored during pulse", d, 16'h1002);
        check("R2 selector spared", {14'b0, op_mode}, 16'h2);
    endtask

    task automatic t_hint();
        @(negedge clk);
        din_wr = 1'b1;
        #1 check("R10 hint when idle", {15'b0, start_hint}, 16'h1);
        eng_busy = 1'b1;
        #1 check("R10 no hint when busy", {15'b0, start_hint}, 16'h0);
        @(negedge clk);
        din_wr = 1'b0; eng_busy = 1'b0;
    endtask

    task automatic t_hw_reset();
        logic [15:0] d;
        ctl_write(16'h1903);
        hw_reset();
        ctl_read(AW'(CTLA), d);
        check("R12 hardware reset clears all", d, 16'h0000);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_modes();
                t_reserved();
                t_ready_irq();
                t_auto_clear();
                t_error();
                t_swrst();
                t_hint();
                t_hw_reset();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=hung expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule